// File: doc/BRIEF.md
# Serial MII Receive Segment Encoder

This block sits on the PHY side of a serial media-independent receive path. It packs the receive state into fixed 10-bit segments and sends them on a single data line. Each segment carries carrier sense, data valid and one byte. That byte is either a received data byte or, between frames, a status byte. A one-clock sync strobe marks the first bit of every segment.

The status byte reports live port conditions: speed, duplex, link, jabber and false carrier. It also reports two flags that describe the frame that just ended: whether any receive error occurred in it, and whether the upper nibble of its last byte was valid. These two flags are captured when a frame ends. They stay unchanged in every status segment until the next frame ends. When the port runs at 10 Mb/s, each sampled byte is sent in ten consecutive segments, so one serial format serves both speeds.

The upstream source holds its inputs steady for a byte period. It may change them in the last bit clock of the final segment of that period.

Top module: `rxseg_encoder`

## Requirements
- R1: `seg_sync` is 1 for exactly one clock in every 10. That clock carries bit 0 of a segment. The first segment starts in the clock that follows the first rising edge after reset is released.
- R2: Segment bit 0 is the sampled carrier sense and bit 1 is the sampled data valid. Bits 2 to 9 carry the byte field, least significant bit first.
- R3: When the sampled data valid is 1, the byte field equals the sampled `rx_data`.
- R4: When the sampled data valid is 0, the byte field is a status byte. Its bit 1 is speed (1 = 100 Mb/s), bit 2 duplex (1 = full), bit 3 link (1 = up), bit 4 jabber (1 = jabber), bit 6 false carrier (1 = detected) and bit 7 is always 1.
- R5: Status bit 0 is 1 when `rx_er` was 1 in any byte sampled with data valid high during the previous frame. The flag clears when a frame starts. `rx_er` sampled while data valid is low has no effect.
- R6: Status bit 5 equals `rx_hi_ok` as sampled with the last data byte of the previous frame.
- R7: Status bits 0 and 5 take their new value in the first status segment after a frame ends. They keep that value in all later status segments until the next frame ends. After reset both read 0.
- R8: The inputs are sampled at the rising edge that ends the previous segment. With `spd_100` = 1 they are sampled for every segment. With `spd_100` = 0 (as sampled) the same segment is sent ten times, and the next sample is taken at the end of the tenth copy.
- R9: While reset is asserted, `ser_data` and `seg_sync` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_crs | input | 1 | Carrier sense |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error for the current byte |
| rx_data | input | 8 | Received byte |
| rx_hi_ok | input | 1 | Upper nibble of the current byte is valid |
| spd_100 | input | 1 | Port speed, 1 = 100 Mb/s |
| full_dup | input | 1 | Duplex, 1 = full |
| link_up | input | 1 | Link state, 1 = up |
| jabber | input | 1 | Jabber condition |
| false_carr | input | 1 | False carrier detected |
| ser_data | output | 1 | Serial segment data |
| seg_sync | output | 1 | Marks the first bit of each segment |

## Verification
The assertions assume that the inputs change only between sampling edges. They also assume that the frame history is built only from byte periods that are actually sampled. Because of this, the hold checks on the captured flags refer to the internal take strobe and not to raw input activity. The stimulus follows this assumption: it sets all inputs once per byte period, in the final bit clock of the period's last segment. It counts ten segments per period at 10 Mb/s and one at 100 Mb/s. Directed frames cover errors seen with data valid high, errors with data valid low, single-byte frames and changes of speed inside a frame. A fixed-seed random run then mixes frame lengths, speeds and port status.

// File: rtl/rxseg_pkg.sv
package rxseg_pkg;
  localparam int BYTE_W = 8;
  localparam int SEG_W  = BYTE_W + 2;

  typedef struct packed {
    logic fc;
    logic jab;
    logic link;
    logic dup;
    logic spd;
  } port_stat_t;

  // Status byte: bit0 err, 1 speed, 2 duplex, 3 link, 4 jabber,
  // 5 upper-nibble valid, 6 false carrier, 7 constant one.
  function automatic logic [BYTE_W-1:0] mk_status(logic err, logic nib,
                                                  port_stat_t ps);
    return {1'b1, ps.fc, nib, ps.jab, ps.link, ps.dup, ps.spd, err};
  endfunction

  // Segment word, transmitted from bit 0 upward.
  function automatic logic [SEG_W-1:0] mk_segment(logic crs, logic dv,
                                                  logic [BYTE_W-1:0] field);
    return {field, dv, crs};
  endfunction
endpackage

// File: rtl/rxseg_timer.sv
module rxseg_timer #(
  parameter int SEG_LEN  = 10,
  parameter int SLOW_REP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic load,
  output logic take,
  output logic sync
);
  localparam int CW = $clog2(SEG_LEN);
  localparam int RW = (SLOW_REP > 1) ? $clog2(SLOW_REP) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEG_LEN - 1);
  localparam logic [RW-1:0] REP_TOP = RW'(SLOW_REP - 1);

  logic [CW-1:0] bit_cnt;
  logic [RW-1:0] rep_cnt;

  assign load = (bit_cnt == LAST);
  assign take = load && (rep_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= LAST;
      rep_cnt <= '0;
      sync    <= 1'b0;
    end else begin
      bit_cnt <= load ? '0 : bit_cnt + 1'b1;
      sync    <= load;
      if (take)
        rep_cnt <= fast ? '0 : REP_TOP;
      else if (load)
        rep_cnt <= rep_cnt - 1'b1;
    end
  end

  // R1
  sync_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (bit_cnt == '0));
  // R1
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !sync);
  // R8
  rep_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_cnt <= REP_TOP);
  // R8
  fast_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fast) |=> (rep_cnt == '0));
endmodule

// File: rtl/rxseg_frame.sv
module rxseg_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic dv,
  input  logic er,
  input  logic hi_ok,
  output logic err_now,
  output logic nib_now
);
  logic in_frame, acc_err, last_nib, lat_err, lat_nib;
  logic frame_start, frame_end;

  assign frame_start = take && dv && !in_frame;
  assign frame_end   = take && !dv && in_frame;

  // Values reported in the status segment built at this take.
  assign err_now = (in_frame && !dv) ? acc_err  : lat_err;
  assign nib_now = (in_frame && !dv) ? last_nib : lat_nib;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      acc_err  <= 1'b0;
      last_nib <= 1'b0;
      lat_err  <= 1'b0;
      lat_nib  <= 1'b0;
    end else if (take) begin
      if (dv) begin
        in_frame <= 1'b1;
        acc_err  <= frame_start ? er : (acc_err | er);
        last_nib <= hi_ok;
      end else if (in_frame) begin
        in_frame <= 1'b0;
        lat_err  <= acc_err;
        lat_nib  <= last_nib;
      end
    end
  end

  // R7
  hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dv) |=> ($stable(lat_err) && $stable(lat_nib)));
  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end) |=> ($stable(lat_err) && $stable(lat_nib)));
  // R5
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !er) |=> !acc_err);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dv && in_frame && acc_err) |=> acc_err);
endmodule

// File: rtl/rxseg_shifter.sv
module rxseg_shifter #(
  parameter int SEG_LEN = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               take,
  input  logic [SEG_LEN-1:0] word_in,
  output logic               ser_bit
);
  logic [SEG_LEN-1:0] hold_word, shreg;
  logic fresh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_word <= '0;
      shreg     <= '0;
      fresh     <= 1'b0;
    end else begin
      fresh <= load;
      if (take) hold_word <= word_in;
      if (load) shreg <= take ? word_in : hold_word;
      else      shreg <= {1'b0, shreg[SEG_LEN-1:1]};
    end
  end

  assign ser_bit = shreg[0];

  // R4
  status_top_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && !shreg[1]) |-> shreg[SEG_LEN-1]);
  // R8
  repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !take) |=> (shreg == $past(hold_word)));
endmodule

// File: rtl/rxseg_encoder.sv
module rxseg_encoder #(
  parameter int SLOW_REP = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_crs,
  input  logic       rx_dv,
  input  logic       rx_er,
  input  logic [7:0] rx_data,
  input  logic       rx_hi_ok,
  input  logic       spd_100,
  input  logic       full_dup,
  input  logic       link_up,
  input  logic       jabber,
  input  logic       false_carr,
  output logic       ser_data,
  output logic       seg_sync
);
  import rxseg_pkg::*;

  logic load, take, err_now, nib_now;
  port_stat_t ps;
  logic [BYTE_W-1:0] field;
  logic [SEG_W-1:0] word;

  rxseg_timer #(.SEG_LEN(SEG_W), .SLOW_REP(SLOW_REP)) u_timer (
    .clk(clk), .rst_n(rst_n), .fast(spd_100),
    .load(load), .take(take), .sync(seg_sync)
  );

  rxseg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .take(take), .dv(rx_dv), .er(rx_er),
    .hi_ok(rx_hi_ok), .err_now(err_now), .nib_now(nib_now)
  );

  always_comb begin
    ps.fc   = false_carr;
    ps.jab  = jabber;
    ps.link = link_up;
    ps.dup  = full_dup;
    ps.spd  = spd_100;
    field   = rx_dv ? rx_data : mk_status(err_now, nib_now, ps);
    word    = mk_segment(rx_crs, rx_dv, field);
  end

  rxseg_shifter #(.SEG_LEN(SEG_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .take(take),
    .word_in(word), .ser_bit(ser_data)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    (!rst_n) |=> (!ser_data && !seg_sync));
endmodule

// File: tb/rxseg_encoder_test.sv
module rxseg_encoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic rx_crs = 0, rx_dv = 0, rx_er = 0, rx_hi_ok = 0;
  logic [7:0] rx_data = 0;
  logic spd_100 = 1, full_dup = 0, link_up = 0, jabber = 0, false_carr = 0;
  logic ser_data, seg_sync;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // bench model of the frame history
  bit m_in = 0, m_acc = 0, m_last = 0, m_err = 0, m_nib = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxseg_encoder uut (
    .clk(clk), .rst_n(rst_n), .rx_crs(rx_crs), .rx_dv(rx_dv), .rx_er(rx_er),
    .rx_data(rx_data), .rx_hi_ok(rx_hi_ok), .spd_100(spd_100),
    .full_dup(full_dup), .link_up(link_up), .jabber(jabber),
    .false_carr(false_carr), .ser_data(ser_data), .seg_sync(seg_sync)
  );

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected segment per the requirements (R2..R7).
  function automatic logic [9:0] expect_word();
    logic [7:0] f;
    if (rx_dv) begin
      f = rx_data;
      m_acc  = m_in ? (m_acc | rx_er) : rx_er;
      m_last = rx_hi_ok;
      m_in   = 1;
    end else begin
      if (m_in) begin
        m_err = m_acc;
        m_nib = m_last;
        m_in  = 0;
      end
      f = {1'b1, false_carr, m_nib, jabber, link_up, full_dup, spd_100, m_err};
    end
    return {f, rx_dv, rx_crs};
  endfunction

  task automatic period(bit crs, bit dv, bit er, bit hi, logic [7:0] d,
                        bit spd, bit dup, bit lnk, bit jab, bit fc);
    logic [9:0] w, got;
    logic [9:0] sy;
    int nseg;
    string tag;
    rx_crs = crs; rx_dv = dv; rx_er = er; rx_hi_ok = hi; rx_data = d;
    spd_100 = spd; full_dup = dup; link_up = lnk; jabber = jab; false_carr = fc;
    w = expect_word();
    nseg = spd ? 1 : 10;
    tag = dv ? "R2 R3" : "R2 R4 R5 R6 R7";
    for (int s = 0; s < nseg; s++) begin
      for (int b = 0; b < 10; b++) begin
        @(negedge clk);
        got[b] = ser_data;
        sy[b]  = seg_sync;
      end
      // R1: sync only at bit 0
      check("R1 sync", int'(sy), 1);
      if (spd) check(tag, int'(got), int'(w));
      else     check({tag, " R8 slow"}, int'(got), int'(w));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9: quiet during reset
    check("R9 ser_data", int'(ser_data), 0);
    check("R9 seg_sync", int'(seg_sync), 0);
    rst_n = 1;
    // R7 reset value: first status shows err=0, nib=0
    period(0, 0, 0, 0, 8'h00, 1, 1, 1, 0, 0);
    // idle error ignored (R5)
    period(0, 0, 1, 1, 8'hFF, 1, 0, 1, 1, 1);
    // 100M frame, error on middle byte (R5), last nibble ok=0 (R6)
    period(1, 1, 0, 1, 8'h5A, 1, 1, 1, 0, 0);
    period(1, 1, 1, 1, 8'hC3, 1, 1, 1, 0, 0);
    period(1, 1, 0, 0, 8'h81, 1, 1, 1, 0, 0);
    period(0, 0, 0, 1, 8'h00, 1, 1, 1, 0, 0);
    period(0, 0, 0, 1, 8'h00, 1, 0, 0, 1, 1); // R7 hold
    // single-byte clean frame clears flag (R5), nib valid (R6)
    period(1, 1, 0, 1, 8'h3C, 1, 0, 1, 0, 0);
    period(1, 0, 1, 0, 8'h00, 1, 0, 1, 0, 0);
    // 10M frame with change to fast mid-frame (R8)
    period(1, 1, 1, 0, 8'hA5, 0, 1, 1, 0, 0);
    period(1, 1, 0, 1, 8'h69, 1, 1, 1, 0, 0);
    period(1, 1, 0, 1, 8'h96, 0, 1, 1, 0, 0);
    period(0, 0, 0, 0, 8'h00, 0, 1, 1, 0, 1);
    period(0, 0, 0, 0, 8'h00, 1, 1, 1, 0, 0);
    // random frames
    for (int k = 0; k < 150; k++) begin
      int len = 1 + ($urandom % 6);
      bit spd = ($urandom % 4) != 0;
      for (int j = 0; j < len; j++)
        period(1, 1, ($urandom % 5) == 0, $urandom % 2, 8'($urandom), spd,
               $urandom % 2, 1, 0, 0);
      for (int j = 0; j < 1 + int'($urandom % 3); j++)
        period($urandom % 2, 0, $urandom % 2, $urandom % 2, 8'($urandom),
               ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
               $urandom % 2, $urandom % 2);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule